// File: doc/BRIEF.md
# Paging Codeword Corrector and Address Matcher

This block sits behind a bit synchronizer in a paging receiver. It takes one 32-bit paging codeword at a time, together with the number of the frame slot (0 to 7) in which the codeword arrived. It repairs bit errors using the BCH(31,21) check field and the even parity bit. It then sorts the repaired word into one of four kinds: synchronisation, idle, address or message. Address words are compared with a bank of programmable user entries. Each entry holds an 18-bit address and the frame number in which that address is allowed to appear.

Codeword layout:

- Bit 31 is the type flag: 0 for an address, 1 for a message.
- Bits 30..11 are the 20-bit payload. In an address word, bits 30..13 are the address and bits 12..11 are the function bits.
- Bits 10..1 are the check field, built from the generator x^10+x^9+x^8+x^6+x^5+x^3+1.
- Bit 0 makes the overall parity even.

The search for the error pattern is sequential. It walks one anchor bit position per clock. For each anchor, it tests every single-error and double-error pattern that includes that position. When burst mode is on, it also tests every burst of up to four adjacent bits that starts at that position. The decode latency is therefore fixed at 32 cycles. A second codeword can be accepted in the same cycle in which the result of the first one is presented.

Top module: `pcw_decoder`

## Requirements
- R1: A codeword is taken when `in_valid` and `in_ready` are both high at a clock edge. The result appears as a one-cycle `out_valid` pulse exactly 32 cycles after that edge. `in_ready` is low for the 31 cycles in between and is high again in the cycle of the pulse. After reset, `in_ready` is high and `out_valid` and `match_valid` are low.
- R2: An error-free codeword is returned unchanged on `out_word`, with `out_uncorr` low.
- R3: With burst mode either on or off, any one or two flipped bits anywhere in bits 31..0 (the parity bit included) are corrected. The result has a zero BCH syndrome and even parity.
- R4: With `burst_en` high, a burst of three or four flipped bits is corrected. The burst must lie in bits 31..1, have its first and last bit in error and span at most four bits. This holds only when no pattern of at most two errors, and no other burst, gives the same syndrome.
- R5: With `burst_en` low, any three flipped bits within bits 31..1 are reported as uncorrectable.
- R6: `out_uncorr` is raised when no accepted correction exists. A correction is accepted only if the repaired word has a zero syndrome and even parity. An uncorrectable word never produces `match_valid`.
- R7: `out_kind` is 2 when the repaired word equals 0x7CD215D8 (synchronisation) and 3 when it equals 0x7A89C197 (idle). Otherwise it is 0 when bit 31 is 0 (address) and 1 when bit 31 is 1 (message).
- R8: `out_payload` carries bits 30..11 of the repaired word.
- R9: Entry i matches when `user_en[i]` is high, `user_addr[i][20:3]` equals word bits 30..13, and `user_addr[i][2:0]` equals the arrival frame. A match raises `match_valid` together with `out_valid`, sets `match_idx` to i, and sets `match_func` to word bits 12..11.
- R10: A disabled entry, or an arrival in a frame other than the entry's frame, gives no match.
- R11: When several entries match, `match_idx` reports the lowest index.
- R12: Message, synchronisation and idle words never match, even when their bits 30..13 equal an entry's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A codeword is offered |
| in_ready | output | 1 | The block can take a codeword |
| in_word | input | 32 | Received codeword |
| in_frame | input | 3 | Frame slot in which the codeword arrived |
| burst_en | input | 1 | Enables burst correction; sampled with the codeword |
| user_en | input | NUM_USERS | Enable bit for each user entry |
| user_addr | input | NUM_USERS x 21 | Per entry: address in [20:3], frame in [2:0] |
| out_valid | output | 1 | One-cycle result strobe |
| out_kind | output | 2 | 0 address, 1 message, 2 sync, 3 idle |
| out_uncorr | output | 1 | The codeword could not be corrected |
| out_word | output | 32 | Repaired codeword |
| out_payload | output | 20 | Repaired bits 30..11 |
| match_valid | output | 1 | An enabled entry matched this address word |
| match_idx | output | clog2(NUM_USERS) | Lowest matching entry |
| match_func | output | 2 | Function bits of the matched word |

## Verification
Two things can happen in the same cycle: the result of one codeword is presented, and the next codeword is accepted. The bench provokes this by offering each new codeword as soon as `in_ready` returns, which is exactly the cycle of the previous `out_valid` pulse. It then confirms that the following result still arrives 32 cycles later and matches its own original codeword. A second overlap occurs inside the search, where a random-error candidate and a burst candidate may both fit. The bench places two-bit errors while burst mode is on and requires the exact original word back. This shows that the random-error candidate takes priority over the burst candidate.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    localparam int CW_W     = 32;
    localparam int SYN_W    = 10;
    localparam int ADDR_W   = 18;
    localparam int FRAME_W  = 3;
    localparam int FUNC_W   = 2;
    localparam int PAY_W    = 20;
    localparam int UADDR_W  = ADDR_W + FRAME_W;
    localparam int SEARCH_N = CW_W - 1;     // anchor positions 1..31
    localparam int LAST_CNT = SEARCH_N - 1;

    localparam logic [SYN_W:0]  GEN_POLY = 11'h769;
    localparam logic [CW_W-1:0] SYNC_CW  = 32'h7CD2_15D8;
    localparam logic [CW_W-1:0] IDLE_CW  = 32'h7A89_C197;

    typedef enum logic [1:0] {
        KIND_ADDR = 2'd0,
        KIND_MSG  = 2'd1,
        KIND_SYNC = 2'd2,
        KIND_IDLE = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_FINISH
    } state_t;

    // one candidate correction found by the search
    typedef struct packed {
        logic            hit;
        logic            single;
        logic [CW_W-1:0] mask;
    } fix_t;

    // remainder of bits 31..1 through the check-field divider
    function automatic logic [SYN_W-1:0] bch_syn(input logic [CW_W-1:0] w);
        logic [SYN_W-1:0] rem;
        logic             fb;
        rem = '0;
        for (int k = CW_W - 1; k >= 1; k--) begin
            fb  = rem[SYN_W-1] ^ w[k];
            rem = {rem[SYN_W-2:0], 1'b0};
            if (fb) rem = rem ^ GEN_POLY[SYN_W-1:0];
        end
        return rem;
    endfunction

    function automatic logic [SYN_W-1:0] pos_syn(input int p);
        return bch_syn(CW_W'(1) << p);
    endfunction

    function automatic kind_t classify(input logic [CW_W-1:0] w);
        if (w == SYNC_CW)      return KIND_SYNC;
        else if (w == IDLE_CW) return KIND_IDLE;
        else if (w[CW_W-1])    return KIND_MSG;
        else                   return KIND_ADDR;
    endfunction

endpackage

// File: rtl/pcw_err_search.sv
module pcw_err_search
    import pcw_pkg::*;
(
    input  logic [SYN_W-1:0] syn,
    input  logic [4:0]       pos,
    input  logic             burst_en,
    output fix_t             rnd,
    output fix_t             bst
);

    logic [SYN_W-1:0] stab [CW_W];
    logic [SYN_W-1:0] sp;

    for (genvar g = 0; g < CW_W; g++) begin : g_tab
        assign stab[g] = pos_syn(g);
    end

    assign sp = stab[pos];

    // single error at pos, or pos paired with any other position
    always_comb begin
        rnd = '0;
        if (syn == sp) begin
            rnd.hit    = 1'b1;
            rnd.single = 1'b1;
            rnd.mask   = CW_W'(1) << pos;
        end else begin
            for (int j = 1; j < CW_W; j++) begin
                if (!rnd.hit && (5'(j) != pos) && ((syn ^ sp) == stab[j])) begin
                    rnd.hit  = 1'b1;
                    rnd.mask = (CW_W'(1) << pos) | (CW_W'(1) << j);
                end
            end
        end
    end

    // bursts that start at pos: any subset of the next three bits
    logic [CW_W-1:0]  bm;
    logic [SYN_W-1:0] bs;
    logic             bok;
    logic [5:0]       q;

    always_comb begin
        bst = '0;
        bm  = '0;
        bs  = '0;
        bok = 1'b0;
        q   = '0;
        for (int p = 0; p < 8; p++) begin
            bm  = CW_W'(1) << pos;
            bs  = sp;
            bok = 1'b1;
            for (int b = 1; b <= 3; b++) begin
                if (p[b-1]) begin
                    q = {1'b0, pos} + 6'(b);
                    if (q[5]) begin
                        bok = 1'b0;
                    end else begin
                        bm = bm | (CW_W'(1) << q[4:0]);
                        bs = bs ^ stab[q[4:0]];
                    end
                end
            end
            if (burst_en && bok && !bst.hit && (bs == syn)) begin
                bst.hit  = 1'b1;
                bst.mask = bm;
            end
        end
    end

endmodule

// File: rtl/pcw_addr_match.sv
module pcw_addr_match
    import pcw_pkg::*;
#(
    parameter  int NUM_USERS = 6,
    localparam int IDX_W     = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1
)(
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [FRAME_W-1:0]                frame,
    input  logic [NUM_USERS-1:0]              user_en,
    input  logic [NUM_USERS-1:0][UADDR_W-1:0] user_addr,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);

    logic [NUM_USERS-1:0] hits;

    for (genvar i = 0; i < NUM_USERS; i++) begin : g_cmp
        assign hits[i] = user_en[i] && (user_addr[i] == {addr, frame});
    end

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = NUM_USERS - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hits;

endmodule

// File: rtl/pcw_decoder.sv
module pcw_decoder
    import pcw_pkg::*;
#(
    parameter  int NUM_USERS = 6,
    localparam int IDX_W     = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1
)(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [CW_W-1:0]                   in_word,
    input  logic [FRAME_W-1:0]                in_frame,
    input  logic                              burst_en,
    input  logic [NUM_USERS-1:0]              user_en,
    input  logic [NUM_USERS-1:0][UADDR_W-1:0] user_addr,
    output logic                              out_valid,
    output logic [1:0]                        out_kind,
    output logic                              out_uncorr,
    output logic [CW_W-1:0]                   out_word,
    output logic [PAY_W-1:0]                  out_payload,
    output logic                              match_valid,
    output logic [IDX_W-1:0]                  match_idx,
    output logic [FUNC_W-1:0]                 match_func
);

    state_t             state;
    logic [4:0]         cnt;
    logic [CW_W-1:0]    cw_q;
    logic [FRAME_W-1:0] frame_q;
    logic [SYN_W-1:0]   syn_q;
    logic               burst_q;
    fix_t               rnd_q, bst_q;
    fix_t               srch_rnd, srch_bst;

    logic               accept;
    logic [4:0]         pos;

    assign in_ready = (state == ST_IDLE) || (state == ST_FINISH);
    assign accept   = in_valid && in_ready;
    assign pos      = cnt + 5'd1;

    pcw_err_search u_search (
        .syn      (syn_q),
        .pos      (pos),
        .burst_en (burst_q),
        .rnd      (srch_rnd),
        .bst      (srch_bst)
    );

    // ---------------- result assembly ----------------
    logic [CW_W-1:0] use_mask;
    logic [CW_W-1:0] fixed;
    logic            have_fix;
    logic            par_fix_ok;
    logic            bad;
    kind_t           kind;
    logic            am_hit;
    logic [IDX_W-1:0] am_idx;

    always_comb begin
        if (rnd_q.hit)                 use_mask = rnd_q.mask;
        else if (burst_q && bst_q.hit) use_mask = bst_q.mask;
        else                           use_mask = '0;

        have_fix   = (syn_q == '0) || rnd_q.hit || (burst_q && bst_q.hit);
        par_fix_ok = (syn_q == '0) || (rnd_q.hit && rnd_q.single);

        fixed = cw_q ^ use_mask;
        if ((^fixed) && par_fix_ok) fixed[0] = ~fixed[0];

        bad  = !have_fix || (^fixed) || (bch_syn(fixed) != '0);
        kind = classify(fixed);
    end

    pcw_addr_match #(.NUM_USERS(NUM_USERS)) u_match (
        .addr      (fixed[CW_W-2 -: ADDR_W]),
        .frame     (frame_q),
        .user_en   (user_en),
        .user_addr (user_addr),
        .hit       (am_hit),
        .idx       (am_idx)
    );

    // ---------------- control and registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            cw_q        <= '0;
            frame_q     <= '0;
            syn_q       <= '0;
            burst_q     <= 1'b0;
            rnd_q       <= '0;
            bst_q       <= '0;
            out_valid   <= 1'b0;
            out_kind    <= '0;
            out_uncorr  <= 1'b0;
            out_word    <= '0;
            out_payload <= '0;
            match_valid <= 1'b0;
            match_idx   <= '0;
            match_func  <= '0;
        end else begin
            out_valid   <= 1'b0;
            match_valid <= 1'b0;

            case (state)
                ST_SEARCH: begin
                    if (srch_rnd.hit && !rnd_q.hit) rnd_q <= srch_rnd;
                    if (srch_bst.hit && !bst_q.hit) bst_q <= srch_bst;
                    cnt <= cnt + 5'd1;
                    if (cnt == 5'(LAST_CNT)) state <= ST_FINISH;
                end
                ST_FINISH: begin
                    out_valid   <= 1'b1;
                    out_kind    <= kind;
                    out_uncorr  <= bad;
                    out_word    <= fixed;
                    out_payload <= fixed[CW_W-2 -: PAY_W];
                    match_valid <= !bad && (kind == KIND_ADDR) && am_hit;
                    match_idx   <= am_idx;
                    match_func  <= fixed[CW_W-2-ADDR_W -: FUNC_W];
                    state       <= ST_IDLE;
                end
                default: ;
            endcase

            if (accept) begin
                cw_q    <= in_word;
                frame_q <= in_frame;
                syn_q   <= bch_syn(in_word);
                burst_q <= burst_en;
                rnd_q   <= '0;
                bst_q   <= '0;
                cnt     <= '0;
                state   <= ST_SEARCH;
            end
        end
    end

endmodule

// File: rtl/pcw_decoder_chk.sv
module pcw_decoder_chk
    import pcw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic [1:0]      out_kind,
    input logic            out_uncorr,
    input logic [CW_W-1:0] out_word,
    input logic            match_valid
);

    localparam int LAT = 32;

    logic [5:0] since;
    logic       lat_hit;
    logic       busy_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= '0;
            lat_hit <= 1'b0;
        end else begin
            lat_hit <= (since == 6'(LAT));
            if (in_valid && in_ready)                    since <= 6'd1;
            else if (since != '0 && since < 6'(LAT))     since <= since + 6'd1;
            else                                         since <= '0;
        end
    end

    assign busy_win = (since != '0) && (since < 6'(LAT));

    a_r1_pulse_on_time: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lat_hit);

    a_r1_pulse_not_missing: assert property (@(posedge clk) disable iff (rst)
        lat_hit |-> out_valid);

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        busy_win |-> !in_ready);

    a_r9_match_needs_addr: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> (out_valid && !out_uncorr && out_kind == 2'd0));

    a_r3_repaired_is_codeword: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_uncorr) |-> ((bch_syn(out_word) == '0) && !(^out_word)));

    a_r7_sync_kind: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_uncorr && out_word == SYNC_CW) |-> (out_kind == 2'd2));

endmodule

bind pcw_decoder pcw_decoder_chk u_chk (.*);

// File: tb/pcw_decoder_test.sv
module pcw_decoder_test;

    localparam int NU = 6;
    localparam logic [31:0] T_SYNC = 32'h7CD2_15D8;
    localparam logic [31:0] T_IDLE = 32'h7A89_C197;
    localparam logic [10:0] T_GEN  = 11'h769;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [31:0]        in_word = '0;
    logic [2:0]         in_frame = '0;
    logic               burst_en = 1'b0;
    logic [NU-1:0]      user_en = '0;
    logic [NU-1:0][20:0] user_addr = '0;
    logic               out_valid;
    logic [1:0]         out_kind;
    logic               out_uncorr;
    logic [31:0]        out_word;
    logic [19:0]        out_payload;
    logic               match_valid;
    logic [2:0]         match_idx;
    logic [1:0]         match_func;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pcw_decoder #(.NUM_USERS(NU)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_frame(in_frame), .burst_en(burst_en),
        .user_en(user_en), .user_addr(user_addr),
        .out_valid(out_valid), .out_kind(out_kind), .out_uncorr(out_uncorr),
        .out_word(out_word), .out_payload(out_payload),
        .match_valid(match_valid), .match_idx(match_idx), .match_func(match_func)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] t_syn(input logic [31:0] w);
        logic [9:0] r = '0;
        logic fb;
        for (int k = 31; k >= 1; k--) begin
            fb = r[9] ^ w[k];
            r  = {r[8:0], 1'b0};
            if (fb) r ^= T_GEN[9:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] encode(input logic [20:0] info);
        logic [31:0] w = {info, 11'b0};
        logic [9:0] r = '0;
        logic fb;
        for (int k = 31; k >= 11; k--) begin
            fb = r[9] ^ w[k];
            r  = {r[8:0], 1'b0};
            if (fb) r ^= T_GEN[9:0];
        end
        w[10:1] = r;
        w[0]    = ^w[31:1];
        return w;
    endfunction

    function automatic logic [1:0] exp_kind(input logic [31:0] w);
        if (w == T_SYNC) return 2'd2;
        if (w == T_IDLE) return 2'd3;
        return w[31] ? 2'd1 : 2'd0;
    endfunction

    // another pattern of <=2 errors or another short burst with the same syndrome
    function automatic bit ambiguous(input logic [31:0] e);
        logic [9:0] s = t_syn(e);
        logic [31:0] p;
        for (int i = 0; i < 32; i++)
            for (int j = i; j < 32; j++) begin
                p = (32'd1 << i) | (32'd1 << j);
                if (p != e && t_syn(p) == s) return 1;
            end
        for (int st = 1; st < 32; st++)
            for (int m = 0; m < 8; m++) begin
                p = 32'd1 << st;
                for (int b = 1; b <= 3; b++)
                    if (m[b-1] && st + b < 32) p |= 32'd1 << (st + b);
                if (p != e && t_syn(p) == s) return 1;
            end
        return 0;
    endfunction

    function automatic logic [31:0] make_burst(input int len);
        logic [31:0] e;
        for (int tries = 0; tries < 200; tries++) begin
            int st = $urandom_range(1, 32 - len);
            e = (32'd1 << st) | (32'd1 << (st + len - 1));
            for (int b = 1; b < len - 1; b++)
                if ($urandom_range(0, 1) == 1) e |= 32'd1 << (st + b);
            if (!ambiguous(e)) return e;
        end
        return 32'd0;
    endfunction

    // send one codeword; checks the R1 timing and, when good, the result fields
    task automatic run(input logic [31:0] sent, input logic [31:0] orig,
                       input logic [2:0] fr, input bit bmode, input bit exp_bad,
                       input string ctag);
        logic [1:0] k;
        bit         m_exp = 0;
        int         m_idx = 0;
        while (!in_ready) @(negedge clk);
        in_word  = sent;
        in_frame = fr;
        burst_en = bmode;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (31) @(negedge clk);
        check(!out_valid, "R1 early strobe", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check(out_valid, "R1 strobe at 32", {31'b0, out_valid}, 32'd1);
        check(in_ready, "R1 ready with result", {31'b0, in_ready}, 32'd1);
        check(out_uncorr == exp_bad, {ctag, " R6 uncorr flag"}, {31'b0, out_uncorr},
              {31'b0, exp_bad});
        if (exp_bad) begin
            check(!match_valid, "R6 no match when uncorrectable", {31'b0, match_valid}, 32'd0);
        end else begin
            k = exp_kind(orig);
            check(out_word == orig, {ctag, " repaired word"}, out_word, orig);
            check(out_kind == k, "R7 kind", {30'b0, out_kind}, {30'b0, k});
            check(out_payload == orig[30:11], "R8 payload", {12'b0, out_payload},
                  {12'b0, orig[30:11]});
            if (k == 2'd0)
                for (int i = NU - 1; i >= 0; i--)
                    if (user_en[i] && user_addr[i] == {orig[30:13], fr}) begin
                        m_exp = 1;
                        m_idx = i;
                    end
            check(match_valid == m_exp, "R9 R10 R12 match presence",
                  {31'b0, match_valid}, {31'b0, m_exp});
            if (m_exp) begin
                check(match_idx == 3'(m_idx), "R11 match index", {29'b0, match_idx}, m_idx);
                check(match_func == orig[12:11], "R9 function bits",
                      {30'b0, match_func}, {30'b0, orig[12:11]});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, e;
        void'($urandom(32'd20240611));
        user_addr[0] = {18'h12345, 3'd2};
        user_addr[1] = {18'h2ABCD, 3'd5};
        user_addr[2] = {T_SYNC[30:13], 3'd0};
        user_addr[3] = {18'h3C3C3, 3'd7};
        user_addr[4] = {18'h3C3C3, 3'd7};
        user_addr[5] = {18'h15555, 3'd1};
        user_en      = 6'b011111;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid && !match_valid, "R1 reset state",
              {29'b0, in_ready, out_valid, match_valid}, 32'h4);

        // R2 R9 clean address of entry 0 in its frame
        w = encode({1'b0, 18'h12345, 2'b10});
        run(w, w, 3'd2, 1'b0, 1'b0, "R2");
        // R10 same address, wrong frame
        run(w, w, 3'd3, 1'b0, 1'b0, "R10");
        // R10 disabled entry
        w = encode({1'b0, 18'h15555, 2'b01});
        run(w, w, 3'd1, 1'b0, 1'b0, "R10");
        // R11 two equal entries
        w = encode({1'b0, 18'h3C3C3, 2'b11});
        run(w ^ 32'h0000_0400, w, 3'd7, 1'b0, 1'b0, "R11");
        // R7 R12 sync with two errors, entry 2 carries its address bits
        run(T_SYNC ^ 32'h8000_0010, T_SYNC, 3'd0, 1'b0, 1'b0, "R3");
        // R7 idle, clean
        run(T_IDLE, T_IDLE, 3'd4, 1'b1, 1'b0, "R2");
        // R12 message whose bits 30..13 equal entry 0 address
        w = encode({1'b1, 18'h12345, 2'b10});
        run(w ^ 32'h0000_0001 ^ 32'h0010_0000, w, 3'd2, 1'b0, 1'b0, "R3");
        // R3 parity bit only
        w = encode({1'b0, 18'h2ABCD, 2'b00});
        run(w ^ 32'h1, w, 3'd5, 1'b0, 1'b0, "R3");
        // R5 three errors without burst mode, address of entry 0
        w = encode({1'b0, 18'h12345, 2'b10});
        run(w ^ 32'h0100_0802, w, 3'd2, 1'b0, 1'b1, "R5");
        e = make_burst(3);
        run(w ^ e, w, 3'd2, 1'b0, 1'b1, "R5");

        // R4 bursts with burst mode on
        for (int n = 0; n < 8; n++) begin
            w = encode({$urandom_range(0, 1) == 1, 20'($urandom)});
            e = make_burst((n % 2 == 0) ? 4 : 3);
            run(w ^ e, w, 3'($urandom), 1'b1, 1'b0, "R4");
        end

        // R3 random mix of codewords and up to two errors, either burst mode
        for (int n = 0; n < 60; n++) begin
            int u  = $urandom_range(0, 5);
            int ne = $urandom_range(0, 2);
            logic [2:0] fr;
            if ($urandom_range(0, 3) == 0) begin
                w  = encode({1'b1, 20'($urandom)});
                fr = 3'($urandom);
            end else if ($urandom_range(0, 1) == 1) begin
                w  = encode({1'b0, user_addr[u][20:3], 2'($urandom)});
                fr = ($urandom_range(0, 3) != 0) ? user_addr[u][2:0] : 3'($urandom);
            end else begin
                w  = encode({1'b0, 18'($urandom), 2'($urandom)});
                fr = 3'($urandom);
            end
            e = '0;
            while ($countones(e) < ne) e |= 32'd1 << $urandom_range(0, 31);
            run(w ^ e, w, fr, $urandom_range(0, 1) == 1, 1'b0, "R3");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule